// File: doc/BRIEF.md
# Real-Time Clock Interrupt Vector Controller

This block collects the five interrupt sources of a real-time clock into one request line. The five sources are a read-ready pulse, an interval event, a user alarm and two prescaler ticks. Each source has a pending flag, which a one-cycle event pulse sets. Each flag has its own enable. The block presents a vector value that identifies the most urgent pending flag that is also enabled. Interrupt service code reads that value and jumps straight to the matching handler.

Any bus access to the vector register, read or write, retires only the flag that the vector names. The bus decoder outside this block turns that access into a single strobe. Service code can also clear any set of flags directly with a masked write.

A mode input selects calendar or counter operation. In counter mode the ready and alarm sources do not exist. Their flags are held clear and their enables have no effect. The three remaining sources keep working as in calendar mode.

Top module: `rtc_irq_vector`

## Requirements
- R1: While `rst_n` is low and after its release, all flags read 0, `vec_o` is 0 and `irq_o` is 0.
- R2: A 1 on `src_evt[i]` in a cycle sets `flags_o[i]` at the next rising edge. The flag stays set until a clear removes it.
- R3: Flag bit positions are ready=0, interval=1, alarm=2, tick0=3 and tick1=4. A lower index has higher priority. `vec_o` is 0 when no enabled flag is pending. Otherwise it is 2, 4, 6, 8 or 10 for the highest-priority enabled pending flag at bit 0, 1, 2, 3 or 4.
- R4: A pending flag whose enable bit in `src_en` is 0 has no effect on `vec_o` or `irq_o`, and it stays pending.
- R5: A cycle with `vec_access` high clears, at the next edge, only the flag that `vec_o` names in that cycle. When `vec_o` is 0 the access changes no flag.
- R6: `irq_o` is 1 exactly when at least one pending flag has its enable set. It stays 1 after a vector access if another enabled flag is still pending.
- R7: A cycle with `sw_clr_we` high clears, at the next edge, every flag whose bit in `sw_clr_mask` is 1. It leaves the other flags unchanged.
- R8: An event pulse on a flag in the same cycle as a clear of that flag, from either source of clears, wins. The flag is set after the edge.
- R9: With `mode_cnt` high (counter mode), flags 0 and 2 are cleared at the next edge and stay 0, and events on them are ignored. Their enable bits have no effect on `vec_o` or `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cnt | input | 1 | 1 = counter mode, 0 = calendar mode |
| src_evt | input | 5 | One-cycle event pulses, one per flag |
| src_en | input | 5 | Per-flag interrupt enables |
| vec_access | input | 1 | Strobe for a read or write of the vector register |
| sw_clr_we | input | 1 | Strobe for a direct flag-clear write |
| sw_clr_mask | input | 5 | Flags to clear when `sw_clr_we` is high |
| irq_o | output | 1 | Combined interrupt request |
| vec_o | output | 4 | Vector value of the most urgent enabled pending flag |
| flags_o | output | 5 | Pending flags |

## Verification
The hardest states to reach from the ports are the ones that combine arbitrary pending flags with arbitrary enables in both modes. Only such states show that a vector access retires exactly one flag and leaves disabled flags alone.

To build each state, the bench first clears every flag with one masked write. It then loads a chosen flag pattern with a single multi-bit event pulse and applies a chosen enable pattern. The bench sweeps every flag and enable combination in each mode and follows each state with an access.

Coincident event-and-clear cycles get separate directed cases. In these cases the event lands on the very flag that the access or masked write is clearing.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int unsigned IRQ_SRC_N    = 5;
    localparam int unsigned SRC_READY    = 0;
    localparam int unsigned SRC_INTERVAL = 1;
    localparam int unsigned SRC_ALARM    = 2;
    localparam int unsigned SRC_TICK0    = 3;
    localparam int unsigned SRC_TICK1    = 4;

    typedef enum logic {
        MODE_CALENDAR = 1'b0,
        MODE_COUNTER  = 1'b1
    } rtc_mode_e;

    // Bits that do not exist as sources in counter mode.
    localparam logic [IRQ_SRC_N-1:0] CNT_HOLD_DEFAULT =
        IRQ_SRC_N'((1 << SRC_READY) | (1 << SRC_ALARM));
endpackage

// File: rtl/rtc_irq_flag_bank.sv
module rtc_irq_flag_bank #(
    parameter int unsigned NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] clr,
    input  logic [NSRC-1:0] hold,
    output logic [NSRC-1:0] q
);
    for (genvar gi = 0; gi < NSRC; gi++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[gi] <= 1'b0;
            else if (hold[gi])
                q[gi] <= 1'b0;
            else if (evt[gi])
                q[gi] <= 1'b1;
            else if (clr[gi])
                q[gi] <= 1'b0;
        end

        // R8
        ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[gi] && !hold[gi]) |=> q[gi]);

        // R9
        held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hold[gi] |=> !q[gi]);
    end
endmodule

// File: rtl/rtc_irq_prio_enc.sv
module rtc_irq_prio_enc #(
    parameter int unsigned NSRC  = 5,
    parameter int unsigned VEC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  active,
    output logic [NSRC-1:0]  grant,
    output logic [VEC_W-1:0] vec,
    output logic             req
);
    logic found;

    always_comb begin
        grant = '0;
        vec   = '0;
        found = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (active[i] && !found) begin
                grant[i] = 1'b1;
                vec      = VEC_W'(2 * (i + 1));
                found    = 1'b1;
            end
        end
    end

    assign req = |active;

    // R3
    vec_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec[0] == 1'b0);

    // R6
    req_has_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req == (vec != '0));
endmodule

// File: rtl/rtc_irq_vector.sv
module rtc_irq_vector
    import rtc_irq_pkg::*;
#(
    parameter int unsigned NSRC = IRQ_SRC_N,
    parameter logic [NSRC-1:0] HOLD_MASK = CNT_HOLD_DEFAULT,
    localparam int unsigned VEC_W = $clog2(2 * NSRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_cnt,
    input  logic [NSRC-1:0]  src_evt,
    input  logic [NSRC-1:0]  src_en,
    input  logic             vec_access,
    input  logic             sw_clr_we,
    input  logic [NSRC-1:0]  sw_clr_mask,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [NSRC-1:0]  flags_o
);
    rtc_mode_e       mode;
    logic [NSRC-1:0] hold;
    logic [NSRC-1:0] eff_en;
    logic [NSRC-1:0] active;
    logic [NSRC-1:0] grant;
    logic [NSRC-1:0] clr;

    assign mode   = rtc_mode_e'(mode_cnt);
    assign hold   = (mode == MODE_COUNTER) ? HOLD_MASK : '0;
    assign eff_en = src_en & ~hold;
    assign active = flags_o & eff_en;
    assign clr    = (sw_clr_we ? sw_clr_mask : '0) | (vec_access ? grant : '0);

    rtc_irq_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (src_evt),
        .clr   (clr),
        .hold  (hold),
        .q     (flags_o)
    );

    rtc_irq_prio_enc #(.NSRC(NSRC), .VEC_W(VEC_W)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .grant  (grant),
        .vec    (vec_o),
        .req    (irq_o)
    );

    // R5
    access_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_access && !sw_clr_we && src_evt == '0 && (flags_o & hold) == '0)
        |=> flags_o == $past(flags_o & ~grant));

    // R2
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_access && !sw_clr_we && !mode_cnt)
        |=> (flags_o & $past(flags_o)) == $past(flags_o));

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & src_en) == '0) |-> (!irq_o && vec_o == '0));
endmodule

// File: tb/sim_rtc_irq_vector.sv
`timescale 1ns/1ps
module sim_rtc_irq_vector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_cnt = 1'b0;
    logic [4:0] src_evt = '0;
    logic [4:0] src_en = '0;
    logic       vec_access = 1'b0;
    logic       sw_clr_we = 1'b0;
    logic [4:0] sw_clr_mask = '0;
    logic       irq_o;
    logic [3:0] vec_o;
    logic [4:0] flags_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rtc_irq_vector u0 (
        .clk(clk), .rst_n(rst_n), .mode_cnt(mode_cnt), .src_evt(src_evt),
        .src_en(src_en), .vec_access(vec_access), .sw_clr_we(sw_clr_we),
        .sw_clr_mask(sw_clr_mask), .irq_o(irq_o), .vec_o(vec_o), .flags_o(flags_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_vec(input int a);
        for (int i = 0; i < 5; i++)
            if (a[i]) return 2 * (i + 1);
        return 0;
    endfunction

    function automatic int low_bit(input int a);
        return a & (-a);
    endfunction

    task automatic clear_all();
        sw_clr_we = 1'b1; sw_clr_mask = 5'h1F;
        @(negedge clk);
        sw_clr_we = 1'b0; sw_clr_mask = '0;
    endtask

    task automatic load(input int f);
        src_evt = 5'(f);
        @(negedge clk);
        src_evt = '0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state, with events and enables applied during reset
        src_evt = 5'h1F; src_en = 5'h1F;
        repeat (3) @(negedge clk);
        check("R1 flags", int'(flags_o), 0);
        check("R1 vec", int'(vec_o), 0);
        check("R1 irq", int'(irq_o), 0);
        src_evt = '0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after release", int'(flags_o), 0);

        // Sweep: both modes, all flag patterns, all enable patterns
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 32; f++) begin
                for (int e = 0; e < 32; e++) begin
                    int hold, fe, a, rem;
                    mode_cnt = m[0];
                    clear_all();
                    src_en = 5'(e);
                    load(f);
                    hold = m ? 5 : 0;
                    fe   = f & ~hold;
                    a    = fe & e & ~hold;
                    check(m ? "R9 flags" : "R2 flags", int'(flags_o), fe);
                    check(m ? "R9 vec" : "R3 R4 vec", int'(vec_o), exp_vec(a));
                    check("R6 irq", int'(irq_o), int'(a != 0));
                    vec_access = 1'b1;
                    @(negedge clk);
                    vec_access = 1'b0;
                    rem = fe & ~low_bit(a);
                    check("R5 flags after access", int'(flags_o), rem);
                    check("R6 irq after access", int'(irq_o), int'((rem & e & ~hold) != 0));
                end
            end
        end
        mode_cnt = 1'b0;

        // R7 partial software clear
        clear_all();
        load(5'h1F);
        sw_clr_we = 1'b1; sw_clr_mask = 5'h0A;
        @(negedge clk);
        sw_clr_we = 1'b0;
        check("R7 partial clear", int'(flags_o), 'h15);

        // R8 event vs vector access on same flag
        clear_all();
        src_en = 5'h02;
        load(5'h02);
        check("R8 vec before", int'(vec_o), 4);
        vec_access = 1'b1; src_evt = 5'h02;
        @(negedge clk);
        vec_access = 1'b0; src_evt = '0;
        check("R8 event beats access", int'(flags_o), 'h02);

        // R8 event vs software clear
        clear_all();
        load(5'h1F);
        sw_clr_we = 1'b1; sw_clr_mask = 5'h1F; src_evt = 5'h10;
        @(negedge clk);
        sw_clr_we = 1'b0; src_evt = '0;
        check("R8 event beats sw clear", int'(flags_o), 'h10);

        // R9 switching to counter mode clears held flags already pending
        clear_all();
        load(5'h1F);
        src_en = 5'h1F;
        mode_cnt = 1'b1;
        check("R9 enable ignored in counter mode", int'(vec_o), 4);
        @(negedge clk);
        check("R9 held flags dropped", int'(flags_o), 'h1A);
        mode_cnt = 1'b0;

        // R1 mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", int'(flags_o), 0);
        check("R1 mid-run irq", int'(irq_o), 0);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule